// File: doc/BRIEF.md
# Three-Level Interrupt Gating Controller

This block gathers interrupt events from N peripheral sources and decides when the processor request line is raised. A maskable source reaches the processor only when three gates are open together: its peripheral-side enable, its controller-side enable, and a clear global mask. Each source has a pending latch that records an event whatever its enables are. A latched event that is still present when the enables are set later raises the request at that point. Software can read the pending bits and discard them before it enables a source.

Among the sources that pass all three gates, the lowest index wins. Its index is shown on an ID output with a valid flag, and an acknowledge clears that source's latch. The non-maskable and hard-fault inputs bypass the global mask. Two reset domains are modelled. A system reset request clears every enable, every pending latch and the mask. A core-only reset clears the mask alone, so enables and stale pending events survive it and can fire as soon as the core comes back.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After the asynchronous reset is released, the mask, both enable vectors and all pending bits read 0, and `cpu_req` and `irq_valid` are 0.
- R2: `irq_valid` is 1 exactly when some source has its pending bit, its peripheral enable (address 1) and its controller enable (address 2) all at 1 while the mask (address 0, bit 0) is 0. `cpu_req` is `irq_valid` OR `nmi_in` OR `hardfault_in`.
- R3: While the mask is 1, `irq_valid` is 0 and `cpu_req` follows only `nmi_in` and `hardfault_in`.
- R4: A 1 on `src_evt[i]` at a rising edge sets pending bit i, whatever the enables are. If the enables are opened later while the bit is still set, the request is raised.
- R5: Pending bits read back at address 3. Writing a 1 to a bit at address 3 clears that bit, and writing a 0 leaves it unchanged.
- R6: When several sources pass the gates, `irq_id` shows the lowest index among them.
- R7: `irq_ack` high at an edge while `irq_valid` is 1 clears the pending bit of the source shown on `irq_id`. If an event for that source arrives at the same edge, the bit stays set.
- R8: Writing 1 to bit 0 at address 4 requests a system reset. The bit always reads 0. The mask, both enable vectors and all pending bits are 0 from the second rising edge after the write, and keep their values until then.
- R9: Writing 1 to bit 1 at address 4 requests a core-only reset. The mask is 0 from the second rising edge after the write. Both enable vectors and the pending bits are kept, so a stale enabled pending source raises `irq_valid` once the mask clears.
- R10: A register write takes effect at the rising edge where `reg_wr` is sampled high. `reg_rdata` shows the addressed register with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | N | Per-source event strobes, sampled at each rising edge |
| nmi_in | input | 1 | Non-maskable request, bypasses the mask |
| hardfault_in | input | 1 | Hard-fault request, bypasses the mask |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: 0 mask, 1 peripheral enables, 2 controller enables, 3 pending, 4 reset control |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Read data for `reg_addr` |
| irq_ack | input | 1 | Acknowledge of the source shown on `irq_id` |
| cpu_req | output | 1 | Processor request |
| irq_valid | output | 1 | A maskable source passes all three gates |
| irq_id | output | clog2(N) | Index of the winning source |

## Verification
Every state change lands at the rising edge where the write, event or acknowledge is sampled. The ID, valid, request and read-data outputs are combinational from that state, so the bench samples them 1 ns after that edge. The two reset requests take one more edge: the bench checks that state is still unchanged one edge after the write, and cleared after the next. Pending bits are read through address 3 right after each sample, while the write strobe is low.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic [2:0] {
    ADDR_MASK = 3'd0,
    ADDR_PEN  = 3'd1,
    ADDR_CEN  = 3'd2,
    ADDR_PEND = 3'd3,
    ADDR_RST  = 3'd4
  } reg_addr_e;

  localparam int unsigned RST_SYS_BIT  = 0;
  localparam int unsigned RST_CORE_BIT = 1;

endpackage

// File: rtl/irq_reset_ctl.sv
module irq_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_req_w,
  input  logic core_req_w,
  output logic rst_ns,
  output logic sys_pulse,
  output logic core_pulse
);

  logic sync_q1, sync_q2;
  logic sys_d, core_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= 1'b1;
      sync_q2 <= sync_q1;
    end
  end

  assign rst_ns = sync_q2;

  always_comb begin
    sys_d  = sys_req_w;
    core_d = core_req_w;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sys_pulse  <= 1'b0;
      core_pulse <= 1'b0;
    end else begin
      sys_pulse  <= sys_d;
      core_pulse <= core_d;
    end
  end

  // R8
  sys_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (sys_pulse && !sys_req_w) |=> !sys_pulse);

  // R9
  core_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (core_pulse && !core_req_w) |=> !core_pulse);

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         sys_clr,
  input  logic         pen_we,
  input  logic         cen_we,
  input  logic         pnd_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ack_vec,
  output logic [N-1:0] pen,
  output logic [N-1:0] cen,
  output logic [N-1:0] pend,
  output logic [N-1:0] armed
);

  logic [N-1:0] pen_d, cen_d;
  logic [N-1:0] clr_vec;

  always_comb begin
    pen_d = pen;
    cen_d = cen;
    if (pen_we) pen_d = wdata;
    if (cen_we) cen_d = wdata;
    if (sys_clr) begin
      pen_d = '0;
      cen_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pen <= '0;
      cen <= '0;
    end else begin
      pen <= pen_d;
      cen <= cen_d;
    end
  end

  assign clr_vec = (pnd_we ? wdata : '0) | ack_vec;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic pend_d;

    always_comb begin
      if (sys_clr)
        pend_d = 1'b0;
      else if (evt[i])
        pend_d = 1'b1;
      else if (clr_vec[i])
        pend_d = 1'b0;
      else
        pend_d = pend[i];
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) pend[i] <= 1'b0;
      else         pend[i] <= pend_d;
    end

    assign armed[i] = pend[i] & pen[i] & cen[i];

    // R4
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (evt[i] && !sys_clr) |=> pend[i]);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (ack_vec[i] && !evt[i]) |=> !pend[i]);
  end

  // R8
  sys_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    sys_clr |=> (pen == '0 && cen == '0 && pend == '0));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N   = 8,
  parameter int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_ns,
  input  logic [N-1:0]   req,
  output logic           valid,
  output logic [IDW-1:0] id
);

  always_comb begin
    valid = 1'b0;
    id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        id    = IDW'(i);
      end
    end
  end

  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    valid |-> (req[id] && ((req & ((N'(1) << id) - N'(1))) == '0)));

  // R2
  none_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (req == '0) |-> !valid);

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int unsigned N   = 8,
  parameter int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src_evt,
  input  logic           nmi_in,
  input  logic           hardfault_in,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [N-1:0]   reg_wdata,
  output logic [N-1:0]   reg_rdata,
  input  logic           irq_ack,
  output logic           cpu_req,
  output logic           irq_valid,
  output logic [IDW-1:0] irq_id
);

  logic         rst_ns;
  logic         sys_pulse, core_pulse;
  logic         wr_mask, wr_pen, wr_cen, wr_pnd, wr_rst;
  logic         mask_q, mask_d;
  logic [N-1:0] pen, cen, pend, armed, gated, ack_vec;

  always_comb begin
    wr_mask = reg_wr && (reg_addr == ADDR_MASK);
    wr_pen  = reg_wr && (reg_addr == ADDR_PEN);
    wr_cen  = reg_wr && (reg_addr == ADDR_CEN);
    wr_pnd  = reg_wr && (reg_addr == ADDR_PEND);
    wr_rst  = reg_wr && (reg_addr == ADDR_RST);
  end

  irq_reset_ctl u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_req_w  (wr_rst && reg_wdata[RST_SYS_BIT]),
    .core_req_w (wr_rst && reg_wdata[RST_CORE_BIT]),
    .rst_ns     (rst_ns),
    .sys_pulse  (sys_pulse),
    .core_pulse (core_pulse)
  );

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = reg_wdata[0];
    if (sys_pulse || core_pulse) mask_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) mask_q <= 1'b0;
    else         mask_q <= mask_d;
  end

  assign ack_vec = (irq_ack && irq_valid) ? (N'(1) << irq_id) : '0;

  irq_src_bank #(.N(N)) u_bank (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .sys_clr (sys_pulse),
    .pen_we  (wr_pen),
    .cen_we  (wr_cen),
    .pnd_we  (wr_pnd),
    .wdata   (reg_wdata),
    .evt     (src_evt),
    .ack_vec (ack_vec),
    .pen     (pen),
    .cen     (cen),
    .pend    (pend),
    .armed   (armed)
  );

  assign gated = mask_q ? '0 : armed;

  irq_pick #(.N(N), .IDW(IDW)) u_pick (
    .clk    (clk),
    .rst_ns (rst_ns),
    .req    (gated),
    .valid  (irq_valid),
    .id     (irq_id)
  );

  assign cpu_req = irq_valid | nmi_in | hardfault_in;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_MASK: reg_rdata[0] = mask_q;
      ADDR_PEN:  reg_rdata    = pen;
      ADDR_CEN:  reg_rdata    = cen;
      ADDR_PEND: reg_rdata    = pend;
      default:   reg_rdata    = '0;
    endcase
  end

  // R3
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    mask_q |-> !irq_valid);

  // R9
  core_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (core_pulse && !sys_pulse && !reg_wr) |=> ($stable(pen) && $stable(cen) && !mask_q));

  // R2
  bypass_req_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (nmi_in || hardfault_in) |-> cpu_req);

endmodule

// File: tb/sim_irq_gate_ctrl.sv
`timescale 1ns/1ps
module sim_irq_gate_ctrl;

  localparam int N = 8;
  localparam int NV = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] src_evt;
  logic       nmi_in, hardfault_in, reg_wr, irq_ack;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cpu_req, irq_valid;
  logic [2:0] irq_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_gate_ctrl #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .nmi_in(nmi_in),
    .hardfault_in(hardfault_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .cpu_req(cpu_req), .irq_valid(irq_valid), .irq_id(irq_id)
  );

  // wr, addr, wdata, evt, ack, nmi, hf | exp_req, exp_valid, exp_id, exp_pend
  localparam logic [35:0] VEC [NV] = '{
    {1'b1,3'd2,8'hFF,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,8'h00},
    {1'b0,3'd0,8'h00,8'h10,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,8'h10},
    {1'b1,3'd1,8'h10,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd4,8'h10},
    {1'b0,3'd0,8'h00,8'h06,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd4,8'h16},
    {1'b1,3'd1,8'hFF,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd1,8'h16},
    {1'b1,3'd0,8'h01,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,3'd0,8'h16},
    {1'b0,3'd0,8'h00,8'h00,1'b0,1'b1,1'b0, 1'b1,1'b0,3'd0,8'h16},
    {1'b0,3'd0,8'h00,8'h00,1'b0,1'b0,1'b1, 1'b1,1'b0,3'd0,8'h16},
    {1'b1,3'd0,8'h00,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd1,8'h16},
    {1'b0,3'd0,8'h00,8'h00,1'b1,1'b0,1'b0, 1'b1,1'b1,3'd2,8'h14},
    {1'b0,3'd0,8'h00,8'h04,1'b1,1'b0,1'b0, 1'b1,1'b1,3'd2,8'h14},
    {1'b1,3'd3,8'h04,8'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd4,8'h10},
    {1'b0,3'd0,8'h00,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b0,3'd0,8'h00},
    {1'b0,3'd0,8'h00,8'h80,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd7,8'h80}
  };

  function automatic string vec_tag(int k);
    case (k)
      0, 2, 8: return "R2";
      1, 3:    return "R4";
      4:       return "R6";
      5, 6, 7: return "R3";
      9, 10, 12: return "R7";
      11:      return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(logic wr, logic [2:0] a, logic [7:0] wd, logic [7:0] ev,
                       logic ak, logic nm, logic hf);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; src_evt = ev;
    irq_ack = ak; nmi_in = nm; hardfault_in = hf;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; src_evt = '0; irq_ack = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic idle();
    apply(1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; src_evt = '0; nmi_in = 1'b0; hardfault_in = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; irq_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    chk("R1 cpu_req", {7'd0, cpu_req}, 8'h00);
    chk("R1 irq_valid", {7'd0, irq_valid}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d);
      chk("R1 register", d, 8'h00);
    end

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [35:0] v;
      v = VEC[k];
      apply(v[35], v[34:32], v[31:24], v[23:16], v[15], v[14], v[13]);
      chk(vec_tag(k), {7'd0, cpu_req}, {7'd0, v[12]});
      chk(vec_tag(k), {7'd0, irq_valid}, {7'd0, v[11]});
      if (v[11]) chk({vec_tag(k), " id"}, {5'd0, irq_id}, {5'd0, v[10:8]});
      rd(3'd3, d);
      chk({vec_tag(k), " pend"}, d, v[7:0]);
    end

    // R10 read back of writes
    rd(3'd1, d); chk("R10 pen", d, 8'hFF);
    rd(3'd2, d); chk("R10 cen", d, 8'hFF);
    rd(3'd0, d); chk("R10 mask", d, 8'h00);

    // R9 core-only reset with stale pending source 7
    apply(1'b1, 3'd0, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3 masked", {7'd0, irq_valid}, 8'h00);
    apply(1'b1, 3'd4, 8'h02, 8'h00, 1'b0, 1'b0, 1'b0);
    rd(3'd4, d); chk("R8 rstctl reads 0", d, 8'h00);
    rd(3'd0, d); chk("R9 mask held one edge", d, 8'h01);
    chk("R9 still blocked", {7'd0, irq_valid}, 8'h00);
    idle();
    rd(3'd0, d); chk("R9 mask cleared", d, 8'h00);
    chk("R9 stale fires", {7'd0, irq_valid}, 8'h01);
    chk("R9 stale id", {5'd0, irq_id}, 8'h07);
    rd(3'd1, d); chk("R9 pen kept", d, 8'hFF);
    rd(3'd2, d); chk("R9 cen kept", d, 8'hFF);
    rd(3'd3, d); chk("R9 pend kept", d, 8'h80);

    // R8 system reset
    apply(1'b1, 3'd4, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
    rd(3'd4, d); chk("R8 sysreq reads 0", d, 8'h00);
    rd(3'd3, d); chk("R8 pend held one edge", d, 8'h80);
    idle();
    rd(3'd3, d); chk("R8 pend cleared", d, 8'h00);
    rd(3'd1, d); chk("R8 pen cleared", d, 8'h00);
    rd(3'd2, d); chk("R8 cen cleared", d, 8'h00);
    chk("R8 no request", {7'd0, cpu_req}, 8'h00);

    // R2 reopen after system reset, source 0
    apply(1'b1, 3'd2, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
    apply(1'b1, 3'd1, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0);
    chk("R2 source 0 valid", {7'd0, irq_valid}, 8'h01);
    chk("R2 source 0 id", {5'd0, irq_id}, 8'h00);
    // R5 write 0 leaves pending unchanged
    apply(1'b1, 3'd3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    rd(3'd3, d); chk("R5 zero write keeps", d, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule